// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block bridges a single internal requester, which issues 32-bit reads and writes with a valid/ready handshake, onto a slow external parallel bus with 20 address lines, 16 data lines, three active-low chip selects and active-low read and write strobes. Internal address bits 21..20 choose one of three banks. Each bank carries its own timing and width settings, so flash, static RAM and other peripherals with different speeds can share the same pins.

Every bank can be set to an 8-bit or 16-bit data path. A 32-bit internal transfer is cut into two or four external cycles, least significant part first, and read pieces are reassembled before the single response. The read and write strobe lengths and the idle gap placed before a write that follows a read are all programmed per bank. Writes to a bank marked read-only and accesses to the unmapped fourth bank code never reach the pins; they return an error response and raise a sticky status flag that stays set until its clear input is pulsed.

Top module: `extbus_ctrl`

## Requirements
- R1: After synchronous reset all chip selects and both strobes are high (inactive), the data output enable is low, both error flags are low and `req_ready` is high.
- R2: Bank code `req_addr[21:20]` values 0, 1 and 2 select `ext_cs_n[0]`, `[1]` and `[2]` respectively; at most one chip select is low at a time, and a strobe is low only while a chip select is low.
- R3: With the bank's width bit at 1 (16-bit) a transfer takes two external cycles at `ext_addr = {0, req_addr[19:2], k}` for k = 0,1, carrying data bits `[16k+15:16k]`; with the width bit at 0 (8-bit) it takes four cycles at `ext_addr = {req_addr[19:2], k[1:0]}` carrying bits `[8k+7:8k]` on `ext_dout[7:0]` with `ext_dout[15:8]` zero, and read data is gathered from `ext_din` the same way.
- R4: In each read cycle the read strobe is low for exactly F+1 clocks, F being the bank's 5-bit read wait field (1 to 32 clocks), and `ext_din` is captured on the last of those clocks.
- R5: In each write cycle the write strobe is low for exactly F+1 clocks, F being the bank's 5-bit write wait field.
- R6: Every external cycle is followed by exactly one clock with all chip selects and strobes high, and a successful transfer returns `resp_valid` T + B*(W+1) + 1 clocks after acceptance (B cycles, W strobe length, T turnaround clocks).
- R7: A write whose previous external cycle was a read waits T = F+1 clocks (F the 4-bit turnaround field of the write's bank, 1 to 16 clocks) with the bus idle before its first strobe; any other transfer has T = 0.
- R8: A write to a bank whose write-protect bit is 1 causes no external cycle, answers with `resp_err` high one clock after acceptance, and sets `wp_err`; reads of that bank work normally.
- R9: Any access with bank code 3 causes no external cycle, answers with `resp_err` high one clock after acceptance, and sets `xfer_err`.
- R10: Each error flag stays set until its clear input is high at a clock edge; when a new error and a clear arrive on the same edge the flag ends up set.
- R11: `ext_doe` is high in every clock where the write strobe is low and in the one clock after it, low otherwise, and `ext_dout` does not change during that hold clock.
- R12: `req_ready` is high only while no transfer is in progress, each accepted request yields exactly one single-clock `resp_valid`, and `resp_err` is low for successful transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Internal byte address; bits 21..20 pick the bank |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_err | output | 1 | Completion with error |
| resp_rdata | output | 32 | Assembled read data |
| cfg_wide | input | 3 | Per bank: 1 = 16-bit, 0 = 8-bit |
| cfg_rd_wait | input | 15 | Per bank 5-bit read strobe length minus one |
| cfg_wr_wait | input | 15 | Per bank 5-bit write strobe length minus one |
| cfg_turn | input | 12 | Per bank 4-bit read-to-write idle length minus one |
| cfg_wprot | input | 3 | Per bank write protect |
| clr_wp_err | input | 1 | Clears the write-protect error flag |
| clr_xfer_err | input | 1 | Clears the transfer error flag |
| wp_err | output | 1 | Sticky write-protect error flag |
| xfer_err | output | 1 | Sticky unmapped-bank error flag |
| ext_addr | output | 20 | External address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | Output enable for the data pins |
| ext_din | input | 16 | External read data |
| ext_cs_n | output | 3 | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
The bound checker watches the pin-level rules on every clock: a single chip select at most, strobes never both low and never without a select, the chip select released in the clock after a strobe, the data enable window around the write strobe with stable data in its hold clock, the single-clock response pulse and the stickiness of both error flags. Strobe lengths per bank, the beat order and addresses, the split of write data and the reassembly of read data, the turnaround gap that depends on the previous access type, and the exact response latency can only be shown by the bench, which compares each transfer against a bus model under directed and randomly drawn bank settings.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_ACT,
    ST_HOLD,
    ST_RESP
  } xb_state_t;

endpackage

// File: rtl/extbus_bank_sel.sv
module extbus_bank_sel #(
  parameter int NBANK = 3,
  parameter int BIW   = 2,
  parameter int WSW   = 5,
  parameter int TAW   = 4
) (
  input  logic [BIW-1:0]       idx,
  input  logic [NBANK-1:0]     cfg_wide,
  input  logic [NBANK*WSW-1:0] cfg_rd_wait,
  input  logic [NBANK*WSW-1:0] cfg_wr_wait,
  input  logic [NBANK*TAW-1:0] cfg_turn,
  input  logic [NBANK-1:0]     cfg_wprot,
  output logic                 sel_ok,
  output logic                 sel_wide,
  output logic [WSW-1:0]       sel_rd,
  output logic [WSW-1:0]       sel_wr,
  output logic [TAW-1:0]       sel_turn,
  output logic                 sel_wp
);
  localparam int NSLOT = 1 << BIW;

  logic           ok_a   [NSLOT];
  logic           wide_a [NSLOT];
  logic [WSW-1:0] rd_a   [NSLOT];
  logic [WSW-1:0] wr_a   [NSLOT];
  logic [TAW-1:0] turn_a [NSLOT];
  logic           wp_a   [NSLOT];

  // Unpack per-bank fields; slots past the last bank decode as unmapped.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NBANK) begin : g_mapped
      assign ok_a[g]   = 1'b1;
      assign wide_a[g] = cfg_wide[g];
      assign rd_a[g]   = cfg_rd_wait[g*WSW +: WSW];
      assign wr_a[g]   = cfg_wr_wait[g*WSW +: WSW];
      assign turn_a[g] = cfg_turn[g*TAW +: TAW];
      assign wp_a[g]   = cfg_wprot[g];
    end else begin : g_hole
      assign ok_a[g]   = 1'b0;
      assign wide_a[g] = 1'b0;
      assign rd_a[g]   = '0;
      assign wr_a[g]   = '0;
      assign turn_a[g] = '0;
      assign wp_a[g]   = 1'b0;
    end
  end

  assign sel_ok   = ok_a[idx];
  assign sel_wide = wide_a[idx];
  assign sel_rd   = rd_a[idx];
  assign sel_wr   = wr_a[idx];
  assign sel_turn = turn_a[idx];
  assign sel_wp   = wp_a[idx];

endmodule

// File: rtl/extbus_wait_cnt.sv
module extbus_wait_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/extbus_lane.sv
module extbus_lane #(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int IDW = 32,
  parameter int BCW = 2
) (
  input  logic [AW-1:0]  addr,
  input  logic           wide,
  input  logic [BCW-1:0] beat,
  input  logic [IDW-1:0] wdata,
  output logic [AW-1:0]  eaddr,
  output logic [DW-1:0]  edata
);
  localparam int HW = DW / 2;

  logic [IDW-1:0] shifted;

  always_comb begin
    if (wide) begin
      eaddr   = {1'b0, addr[AW-1:BCW], beat[BCW-2:0]};
      shifted = wdata >> (int'(beat) * DW);
      edata   = shifted[DW-1:0];
    end else begin
      eaddr   = {addr[AW-1:BCW], beat};
      shifted = wdata >> (int'(beat) * HW);
      edata   = {{(DW-HW){1'b0}}, shifted[HW-1:0]};
    end
  end

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int IAW   = 32,
  parameter int IDW   = 32,
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int WSW   = 5,
  parameter int TAW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [IAW-1:0]       req_addr,
  input  logic [IDW-1:0]       req_wdata,
  output logic                 resp_valid,
  output logic                 resp_err,
  output logic [IDW-1:0]       resp_rdata,
  input  logic [NBANK-1:0]     cfg_wide,
  input  logic [NBANK*WSW-1:0] cfg_rd_wait,
  input  logic [NBANK*WSW-1:0] cfg_wr_wait,
  input  logic [NBANK*TAW-1:0] cfg_turn,
  input  logic [NBANK-1:0]     cfg_wprot,
  input  logic                 clr_wp_err,
  input  logic                 clr_xfer_err,
  output logic                 wp_err,
  output logic                 xfer_err,
  output logic [AW-1:0]        ext_addr,
  output logic [DW-1:0]        ext_dout,
  output logic                 ext_doe,
  input  logic [DW-1:0]        ext_din,
  output logic [NBANK-1:0]     ext_cs_n,
  output logic                 ext_rd_n,
  output logic                 ext_wr_n
);
  localparam int BIW = $clog2(NBANK + 1);
  localparam int HW  = DW / 2;
  localparam int NBN = IDW / HW;
  localparam int NBW = IDW / DW;
  localparam int BCW = $clog2(NBN);
  localparam int CW  = (WSW > TAW) ? WSW : TAW;
  localparam logic [BCW-1:0] LAST_N = BCW'(NBN - 1);
  localparam logic [BCW-1:0] LAST_W = BCW'(NBW - 1);

  xb_state_t      st_q, st_d;
  logic [BIW-1:0] bank_q;
  logic           wr_q, wide_q, err_q, last_rd_q;
  logic [AW-1:0]  a_q;
  logic [IDW-1:0] wd_q, rd_acc_q;
  logic [BCW-1:0] beat_q, beat_d;

  logic           accept;
  logic [BIW-1:0] e_bank;
  logic           e_wr, e_wide, e_err;
  logic [AW-1:0]  e_a;
  logic [IDW-1:0] e_wd;

  logic           sel_ok, sel_wide, sel_wp;
  logic [WSW-1:0] sel_rd, sel_wr;
  logic [TAW-1:0] sel_turn;

  logic           cnt_load, cnt_zero, cap, set_wp, set_xf;
  logic [CW-1:0]  cnt_val, ws_val;
  logic [AW-1:0]  lane_addr;
  logic [DW-1:0]  lane_data;

  logic [NBANK-1:0] cs_n_q;
  logic             rd_n_q, wr_n_q, doe_q, rv_q, re_q, wpf_q, xff_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    dout_q;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_addr[IAW-1:AW+BIW], req_addr[BCW-1:0]};

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign e_bank = accept ? req_addr[AW+BIW-1:AW] : bank_q;
  assign e_wr   = accept ? req_write : wr_q;
  assign e_a    = accept ? req_addr[AW-1:0] : a_q;
  assign e_wd   = accept ? req_wdata : wd_q;
  assign e_wide = accept ? sel_wide : wide_q;
  assign e_err  = accept ? (!sel_ok || (req_write && sel_wp)) : err_q;

  extbus_bank_sel #(.NBANK(NBANK), .BIW(BIW), .WSW(WSW), .TAW(TAW)) u_sel (
    .idx(e_bank), .cfg_wide(cfg_wide), .cfg_rd_wait(cfg_rd_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_turn(cfg_turn), .cfg_wprot(cfg_wprot),
    .sel_ok(sel_ok), .sel_wide(sel_wide), .sel_rd(sel_rd), .sel_wr(sel_wr),
    .sel_turn(sel_turn), .sel_wp(sel_wp)
  );

  extbus_wait_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  extbus_lane #(.AW(AW), .DW(DW), .IDW(IDW), .BCW(BCW)) u_lane (
    .addr(e_a), .wide(e_wide), .beat(beat_d), .wdata(e_wd),
    .eaddr(lane_addr), .edata(lane_data)
  );

  assign ws_val = CW'(e_wr ? sel_wr : sel_rd);

  // Sequencer: optional turnaround, then strobe/hold pairs per beat.
  always_comb begin
    st_d     = st_q;
    beat_d   = beat_q;
    cnt_load = 1'b0;
    cnt_val  = ws_val;
    cap      = 1'b0;
    set_wp   = 1'b0;
    set_xf   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        beat_d = '0;
        if (!sel_ok) begin
          st_d   = ST_RESP;
          set_xf = 1'b1;
        end else if (req_write && sel_wp) begin
          st_d   = ST_RESP;
          set_wp = 1'b1;
        end else if (req_write && last_rd_q) begin
          st_d     = ST_TURN;
          cnt_load = 1'b1;
          cnt_val  = CW'(sel_turn);
        end else begin
          st_d     = ST_ACT;
          cnt_load = 1'b1;
        end
      end
      ST_TURN: if (cnt_zero) begin
        st_d     = ST_ACT;
        cnt_load = 1'b1;
      end
      ST_ACT: if (cnt_zero) begin
        st_d = ST_HOLD;
        cap  = !wr_q;
      end
      ST_HOLD: begin
        if (beat_q == (wide_q ? LAST_W : LAST_N)) begin
          st_d = ST_RESP;
        end else begin
          beat_d   = beat_q + 1'b1;
          st_d     = ST_ACT;
          cnt_load = 1'b1;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bank_q    <= '0;
      wr_q      <= 1'b0;
      wide_q    <= 1'b0;
      err_q     <= 1'b0;
      last_rd_q <= 1'b0;
      a_q       <= '0;
      wd_q      <= '0;
      rd_acc_q  <= '0;
      beat_q    <= '0;
      wpf_q     <= 1'b0;
      xff_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      if (accept) begin
        bank_q   <= e_bank;
        wr_q     <= e_wr;
        wide_q   <= e_wide;
        err_q    <= e_err;
        a_q      <= e_a;
        wd_q     <= e_wd;
        rd_acc_q <= '0;
      end
      if (cap) begin
        if (wide_q) rd_acc_q[int'(beat_q)*DW +: DW] <= ext_din;
        else        rd_acc_q[int'(beat_q)*HW +: HW] <= ext_din[HW-1:0];
      end
      if (st_q == ST_ACT && cnt_zero) last_rd_q <= !wr_q;
      wpf_q <= set_wp | (wpf_q & ~clr_wp_err);
      xff_q <= set_xf | (xff_q & ~clr_xfer_err);
    end
  end

  // Registered pin drivers, loaded from the next-state decode.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q <= '1;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      doe_q  <= 1'b0;
      addr_q <= '0;
      dout_q <= '0;
      rv_q   <= 1'b0;
      re_q   <= 1'b0;
    end else begin
      for (int i = 0; i < NBANK; i++)
        cs_n_q[i] <= !(st_d == ST_ACT && e_bank == BIW'(i));
      rd_n_q <= !(st_d == ST_ACT && !e_wr);
      wr_n_q <= !(st_d == ST_ACT && e_wr);
      doe_q  <= e_wr && (st_d == ST_ACT || st_d == ST_HOLD);
      if (st_d == ST_ACT) begin
        addr_q <= lane_addr;
        dout_q <= lane_data;
      end
      rv_q <= (st_d == ST_RESP);
      re_q <= (st_d == ST_RESP) && e_err;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign resp_valid = rv_q;
  assign resp_err   = re_q;
  assign resp_rdata = rd_acc_q;
  assign wp_err     = wpf_q;
  assign xfer_err   = xff_q;
  assign ext_addr   = addr_q;
  assign ext_dout   = dout_q;
  assign ext_doe    = doe_q;
  assign ext_cs_n   = cs_n_q;
  assign ext_rd_n   = rd_n_q;
  assign ext_wr_n   = wr_n_q;

endmodule

// File: rtl/extbus_ctrl_chk.sv
module extbus_ctrl_chk #(
  parameter int NBANK = 3,
  parameter int IAW   = 32,
  parameter int IDW   = 32,
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int WSW   = 5,
  parameter int TAW   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [IAW-1:0]       req_addr,
  input logic [IDW-1:0]       req_wdata,
  input logic                 resp_valid,
  input logic                 resp_err,
  input logic [IDW-1:0]       resp_rdata,
  input logic [NBANK-1:0]     cfg_wide,
  input logic [NBANK*WSW-1:0] cfg_rd_wait,
  input logic [NBANK*WSW-1:0] cfg_wr_wait,
  input logic [NBANK*TAW-1:0] cfg_turn,
  input logic [NBANK-1:0]     cfg_wprot,
  input logic                 clr_wp_err,
  input logic                 clr_xfer_err,
  input logic                 wp_err,
  input logic                 xfer_err,
  input logic [AW-1:0]        ext_addr,
  input logic [DW-1:0]        ext_dout,
  input logic                 ext_doe,
  input logic [DW-1:0]        ext_din,
  input logic [NBANK-1:0]     ext_cs_n,
  input logic                 ext_rd_n,
  input logic                 ext_wr_n
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&ext_cs_n && ext_rd_n && ext_wr_n && !ext_doe && !wp_err && !xfer_err));

  a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_cs_n));

  a_r2_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n));

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  a_r6_release_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_rd_n) |-> (&ext_cs_n && ext_wr_n));

  a_r6_release_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_wr_n) |-> (&ext_cs_n && ext_rd_n));

  a_r11_doe_window: assert property (@(posedge clk) disable iff (rst)
    ext_doe |-> (!ext_wr_n || !$past(ext_wr_n)));

  a_r11_doe_with_write: assert property (@(posedge clk) disable iff (rst)
    !ext_wr_n |-> ext_doe);

  a_r11_hold_data: assert property (@(posedge clk) disable iff (rst)
    (ext_doe && ext_wr_n) |-> $stable(ext_dout));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  a_r12_busy_on_resp: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !req_ready);

  a_r12_err_only_on_resp: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> resp_valid);

  a_r10_wp_sticky: assert property (@(posedge clk) disable iff (rst)
    (wp_err && !clr_wp_err) |=> wp_err);

  a_r10_xfer_sticky: assert property (@(posedge clk) disable iff (rst)
    (xfer_err && !clr_xfer_err) |=> xfer_err);

endmodule

bind extbus_ctrl extbus_ctrl_chk #(
  .NBANK(NBANK), .IAW(IAW), .IDW(IDW), .AW(AW), .DW(DW), .WSW(WSW), .TAW(TAW)
) u_chk (.*);

// File: tb/tb_extbus_ctrl.sv
module tb_extbus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [2:0]  cfg_wide, cfg_wprot;
  logic [14:0] cfg_rd_wait, cfg_wr_wait;
  logic [11:0] cfg_turn;
  logic        clr_wp_err, clr_xfer_err, wp_err, xfer_err;
  logic [19:0] ext_addr;
  logic [15:0] ext_dout, ext_din;
  logic        ext_doe, ext_rd_n, ext_wr_n;
  logic [2:0]  ext_cs_n;

  int total = 0;
  int bad   = 0;
  bit last_rd = 1'b0;
  bit exp_wp  = 1'b0;
  bit exp_xf  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extbus_ctrl dut (.*);

  function automatic logic [15:0] model(input int b, input logic [19:0] ea);
    return {ea[7:0] ^ {ea[19:16], 2'b00, 2'(b)}, ea[15:8] + 8'h3C};
  endfunction

  always_comb begin
    int b;
    b = (ext_cs_n == 3'b110) ? 0 : (ext_cs_n == 3'b101) ? 1 : 2;
    ext_din = model(b, ext_addr);
  end

  function automatic logic [19:0] exp_eaddr(input logic [31:0] a, input bit wide, input int k);
    return wide ? {1'b0, a[19:2], 1'(k)} : {a[19:2], 2'(k)};
  endfunction

  function automatic logic [15:0] exp_lane(input logic [31:0] d, input bit wide, input int k);
    return wide ? d[k*16 +: 16] : {8'h00, d[k*8 +: 8]};
  endfunction

  function automatic logic [31:0] exp_read(input int b, input logic [31:0] a, input bit wide);
    logic [31:0] r = '0;
    for (int k = 0; k < (wide ? 2 : 4); k++) begin
      logic [15:0] m = model(b, exp_eaddr(a, wide, k));
      if (wide) r[k*16 +: 16] = m;
      else      r[k*8 +: 8]   = m[7:0];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_bank(input int b, input bit wide, input int rd, input int wr,
                          input int turn, input bit wp);
    cfg_wide[b]          = wide;
    cfg_rd_wait[b*5 +: 5] = 5'(rd);
    cfg_wr_wait[b*5 +: 5] = 5'(wr);
    cfg_turn[b*4 +: 4]    = 4'(turn);
    cfg_wprot[b]         = wp;
  endtask

  task automatic do_req(input bit wr, input int b, input logic [19:0] lo,
                        input logic [31:0] wd, input bit clr_wp);
    logic [31:0] a = {10'h0, 2'(b), lo};
    bit ok    = (b < 3);
    bit wide  = ok ? cfg_wide[b] : 1'b0;
    bit wp    = ok && wr && cfg_wprot[b];
    bit err   = !ok || wp;
    int nb    = err ? 0 : (wide ? 2 : 4);
    int w     = ok ? (wr ? int'(cfg_wr_wait[b*5 +: 5]) : int'(cfg_rd_wait[b*5 +: 5])) + 1 : 0;
    int t     = (!err && wr && last_rd) ? int'(cfg_turn[b*4 +: 4]) + 1 : 0;
    int n = 0, beats = 0, first = -1, doe_bad = 0;
    bit prev_s = 1'b0, prev_w = 1'b0;
    logic [19:0] ba [4];
    logic [15:0] bd [4];
    logic [2:0]  bc [4];
    int          bl [4];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; clr_wp_err = clr_wp;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; clr_wp_err = 1'b0;
    forever begin
      bit s = !ext_rd_n || !ext_wr_n;
      n++;
      if (ext_doe != (!ext_wr_n || prev_w)) doe_bad++;
      if (s && first < 0) first = n;
      if (s && !prev_s) begin
        if (beats < 4) begin
          ba[beats] = ext_addr; bd[beats] = ext_dout; bc[beats] = ext_cs_n; bl[beats] = 1;
        end
        beats++;
      end else if (s && beats <= 4) begin
        bl[beats-1]++;
      end
      prev_s = s; prev_w = !ext_wr_n;
      if (resp_valid || n > 3000) break;
      @(negedge clk);
    end
    chk(beats == nb, err ? (ok ? "R8 beats" : "R9 beats") : "R3 beats", beats, nb);
    chk(n == (err ? 1 : t + nb*(w+1) + 1), "R6 latency", n, err ? 1 : t + nb*(w+1) + 1);
    chk(resp_err == err, err ? (ok ? "R8 resp_err" : "R9 resp_err") : "R12 resp_err", resp_err, err);
    chk(doe_bad == 0, "R11 doe window", doe_bad, 0);
    if (t > 0) chk(first == t + 1, "R7 turnaround", first, t + 1);
    for (int k = 0; k < nb && k < beats; k++) begin
      chk(bc[k] == ~(3'b1 << b), "R2 select", bc[k], ~(3'b1 << b));
      chk(ba[k] == exp_eaddr(a, wide, k), "R3 address", ba[k], exp_eaddr(a, wide, k));
      chk(bl[k] == w, wr ? "R5 strobe len" : "R4 strobe len", bl[k], w);
      if (wr) chk(bd[k] == exp_lane(wd, wide, k), "R3 write lane", bd[k], exp_lane(wd, wide, k));
    end
    if (!wr && !err) chk(resp_rdata == exp_read(b, a, wide), "R3 read data", resp_rdata, exp_read(b, a, wide));
    exp_wp = wp | (exp_wp & !clr_wp);
    exp_xf = !ok | exp_xf;
    chk(wp_err == exp_wp, "R10 wp flag", wp_err, exp_wp);
    chk(xfer_err == exp_xf, "R10 xfer flag", xfer_err, exp_xf);
    if (!err) last_rd = !wr;
    @(negedge clk);
    chk(req_ready && !resp_valid, "R12 back to idle", {req_ready, resp_valid}, 2'b10);
  endtask

  task automatic pulse_clr(input bit cw, input bit cx);
    @(negedge clk);
    clr_wp_err = cw; clr_xfer_err = cx;
    @(negedge clk);
    clr_wp_err = 1'b0; clr_xfer_err = 1'b0;
    if (cw) exp_wp = 1'b0;
    if (cx) exp_xf = 1'b0;
    chk(wp_err == exp_wp && xfer_err == exp_xf, "R10 clear", {wp_err, xfer_err}, {exp_wp, exp_xf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    clr_wp_err = 1'b0; clr_xfer_err = 1'b0;
    cfg_wide = '0; cfg_wprot = '0; cfg_rd_wait = '0; cfg_wr_wait = '0; cfg_turn = '0;
    set_bank(0, 1'b1, 2, 1, 2, 1'b0);
    set_bank(1, 1'b0, 0, 3, 0, 1'b0);
    set_bank(2, 1'b1, 31, 0, 15, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(&ext_cs_n && ext_rd_n && ext_wr_n && !ext_doe, "R1 pins idle",
        {ext_cs_n, ext_rd_n, ext_wr_n, ext_doe}, 6'b111110);
    chk(req_ready && !wp_err && !xfer_err && !resp_valid, "R1 status",
        {req_ready, wp_err, xfer_err, resp_valid}, 4'b1000);

    // Directed corner cases
    do_req(1'b0, 0, 20'h12344, '0, 1'b0);            // R3 wide read
    do_req(1'b1, 0, 20'hABCD8, 32'hCAFEBABE, 1'b0);  // R7 write after read
    do_req(1'b1, 0, 20'h00010, 32'h01234567, 1'b0);  // R7 write after write, no gap
    do_req(1'b0, 1, 20'hFFFFC, '0, 1'b0);            // R3 narrow read, top address
    do_req(1'b1, 1, 20'h00000, 32'hA1B2C3D4, 1'b0);  // R7 one-clock turnaround, narrow write
    do_req(1'b1, 2, 20'h00040, 32'hDEADBEEF, 1'b0);  // R8 protected write
    do_req(1'b0, 2, 20'h55554, '0, 1'b0);            // R8 protected bank still readable, R4 32 clocks
    do_req(1'b1, 2, 20'h00044, 32'h11112222, 1'b1);  // R10 set and clear on the same edge
    do_req(1'b0, 3, 20'h00100, '0, 1'b0);            // R9 unmapped read
    do_req(1'b1, 3, 20'h00100, 32'h5, 1'b0);         // R9 unmapped write
    pulse_clr(1'b1, 1'b0);
    pulse_clr(1'b0, 1'b1);

    // Random traffic with periodically redrawn bank settings
    for (int i = 0; i < 120; i++) begin
      if (i % 12 == 0)
        for (int b = 0; b < 3; b++)
          set_bank(b, 1'($urandom % 2), int'($urandom % 32), int'($urandom % 32),
                   int'($urandom % 16), ($urandom % 4) == 0);
      do_req(1'($urandom % 2), int'($urandom % 4), 20'($urandom), $urandom,
             ($urandom % 8) == 0);
      if (i % 20 == 19) pulse_clr(1'b1, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule